// File: doc/BRIEF.md
# Limited-Pointer Sharer Directory Entry

This block keeps the coherence directory state of one memory block for a machine of `NODES` nodes. It does not keep one presence bit per node. It keeps a small fixed set of pointer slots, and each slot holds the ID of one sharing node. Commands arrive on a valid/ready command port. They add a sharer, remove a sharer, clear the entry, make one node the exclusive owner, or start an invalidation on behalf of a requesting node. The current sharer list, the overflow flag and the owned flag are always visible on plain status outputs.

A new sharer may arrive when every slot is already taken. In that case the entry gives up exact tracking and enters overflow mode. An invalidation in pointer mode targets only the listed sharers. In overflow mode it falls back to a coarse sweep of every node ID. In both modes the requester is skipped. Targets leave on a valid/ready stream. A target that is offered stays stable until the consumer accepts it, and at most one target is accepted per cycle. The command port stays not-ready until the sweep has finished.

When the last target has been taken, a single-cycle done pulse is raised. The entry then records the requester as its sole owner.

Top module: `limptr_dir_entry`

## Requirements
- R1: After reset the entry has no valid slots, overflow and owned are 0, `cmd_ready` is 1 and `tgt_valid` is 0.
- R2: A command is accepted on a cycle where `cmd_valid` and `cmd_ready` are both high. The `cmd_op` codes are 0 add, 1 remove, 2 clear, 3 set-owner and 4 invalidate. Codes 5 to 7 are accepted and change nothing.
- R3: Adding a node ID that is absent writes it into the lowest-numbered free slot. Adding an ID that is already listed changes nothing, so no two valid slots ever hold the same ID.
- R4: Removing a listed ID frees its slot. Removing an ID that is not listed changes nothing.
- R5: Adding a new ID while all `SLOTS` slots are valid sets `overflow` and empties the slot list. While `overflow` is set, add and remove commands have no effect.
- R6: A clear command empties all slots and clears both `overflow` and `owned`.
- R7: Set-owner leaves exactly slot 0 valid, holding the given ID, sets `owned` and clears `overflow`. An add that writes a slot, or a remove that frees one, clears `owned`.
- R8: An invalidation in pointer mode emits the IDs of the valid slots in ascending slot order and skips a slot holding the requester's ID.
- R9: An invalidation in overflow mode emits every node ID from 0 to `NODES-1` in ascending order, except the requester.
- R10: While `tgt_valid` is high and `tgt_ready` is low, `tgt_node` holds its value. `cmd_ready` is low from the acceptance of an invalidation until the cycle after the done pulse.
- R11: `inval_done` is high for exactly one cycle: the cycle after the last target handshake, or the cycle after acceptance if there are no targets. On the next cycle the entry holds only the requester in slot 0, with `owned` set and `overflow` clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Entry can take a command (low during an invalidation sweep) |
| cmd_op | input | 3 | Operation code (see R2) |
| cmd_node | input | ID_W | Node ID for the command; the requester for an invalidation |
| tgt_valid | output | 1 | Invalidation target offered |
| tgt_ready | input | 1 | Consumer takes the target |
| tgt_node | output | ID_W | Node ID to invalidate |
| inval_done | output | 1 | One-cycle pulse ending a sweep |
| sharer_valid | output | SLOTS | Per-slot valid bits |
| sharer_ids | output | SLOTS*ID_W | Slot k's ID at bits [k*ID_W +: ID_W] |
| overflow | output | 1 | Exact tracking lost; sweeps cover all nodes |
| owned | output | 1 | Entry is held exclusively by slot 0 |

## Verification
The assertions assume that `cmd_node` is a legal node ID below `NODES`. They also assume that the consumer never withdraws the target stream while a target is pending. The bench keeps `NODES` at a power of two, so every driven ID is in range. It drives `tgt_ready` only at falling edges, with steady or alternating patterns. It also offers commands only while `cmd_ready` is high, so each acceptance lands on a known edge and the expected state can be computed for the following cycle.

// File: rtl/lpdir_pkg.sv
`timescale 1ns/1ps
package lpdir_pkg;
  typedef enum logic [2:0] {
    OP_ADD    = 3'd0,
    OP_REMOVE = 3'd1,
    OP_CLEAR  = 3'd2,
    OP_OWNER  = 3'd3,
    OP_INVAL  = 3'd4
  } dir_op_e;
endpackage

// File: rtl/lpdir_slot_table.sv
`timescale 1ns/1ps
// Pointer slot storage: lookup, lowest-free allocation, overflow and owner state.
module lpdir_slot_table #(
  parameter int NODES = 16,
  parameter int SLOTS = 5,
  localparam int ID_W = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        add_en,
  input  logic                        rem_en,
  input  logic                        clr_en,
  input  logic                        own_en,
  input  logic [ID_W-1:0]             node,
  input  logic [ID_W-1:0]             own_node,
  output logic [SLOTS-1:0]            slot_vld,
  output logic [SLOTS-1:0][ID_W-1:0]  slot_id,
  output logic [SLOTS-1:0]            match_vec,
  output logic                        ovf,
  output logic                        owned_q
);
  logic [SLOTS-1:0] free_vec, free_oh;
  logic             hit, full;

  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : g_match
      assign match_vec[g] = slot_vld[g] && (slot_id[g] == node);
    end
  endgenerate

  assign hit      = |match_vec;
  assign full     = &slot_vld;
  assign free_vec = ~slot_vld;
  assign free_oh  = free_vec & (~free_vec + SLOTS'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_vld <= '0;
      slot_id  <= '0;
      ovf      <= 1'b0;
      owned_q  <= 1'b0;
    end else if (clr_en) begin
      slot_vld <= '0;
      ovf      <= 1'b0;
      owned_q  <= 1'b0;
    end else if (own_en) begin
      slot_vld    <= SLOTS'(1);
      slot_id[0]  <= own_node;
      ovf         <= 1'b0;
      owned_q     <= 1'b1;
    end else if (add_en && !ovf && !hit) begin
      owned_q <= 1'b0;
      if (full) begin
        ovf      <= 1'b1;
        slot_vld <= '0;
      end else begin
        for (int k = 0; k < SLOTS; k++) begin
          if (free_oh[k]) begin
            slot_vld[k] <= 1'b1;
            slot_id[k]  <= node;
          end
        end
      end
    end else if (rem_en && !ovf && hit) begin
      slot_vld <= slot_vld & ~match_vec;
      owned_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/lpdir_inval_walker.sv
`timescale 1ns/1ps
// Invalidation sweep: pending-slot walk or full node sweep, skipping the requester.
module lpdir_inval_walker #(
  parameter int NODES = 16,
  parameter int SLOTS = 5,
  localparam int ID_W = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int CW   = ID_W + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic                        bcast,
  input  logic [ID_W-1:0]             req_node,
  input  logic [SLOTS-1:0]            pend_init,
  input  logic [SLOTS-1:0][ID_W-1:0]  slot_id,
  input  logic                        tgt_ready,
  output logic                        busy,
  output logic                        tgt_valid,
  output logic [ID_W-1:0]             tgt_node,
  output logic                        done,
  output logic [ID_W-1:0]             req_q
);
  logic             mode_b;
  logic [SLOTS-1:0] pend, pend_oh;
  logic [CW-1:0]    cnt;
  logic [ID_W-1:0]  ptr_id;
  logic             live;

  function automatic logic [CW-1:0] step(input logic [CW-1:0] c, input logic [ID_W-1:0] r);
    logic [CW-1:0] n;
    n = c + CW'(1);
    if (n == {1'b0, r}) n = c + CW'(2);
    return n;
  endfunction

  assign pend_oh = pend & (~pend + SLOTS'(1));

  always_comb begin
    ptr_id = '0;
    for (int k = 0; k < SLOTS; k++)
      if (pend_oh[k]) ptr_id = ptr_id | slot_id[k];
  end

  assign live      = mode_b ? (cnt < CW'(NODES)) : (|pend);
  assign tgt_valid = busy && live;
  assign tgt_node  = mode_b ? cnt[ID_W-1:0] : ptr_id;
  assign done      = busy && !live;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      mode_b <= 1'b0;
      pend   <= '0;
      cnt    <= '0;
      req_q  <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      mode_b <= bcast;
      pend   <= pend_init;
      cnt    <= (req_node == '0) ? CW'(1) : '0;
      req_q  <= req_node;
    end else if (busy) begin
      if (done) begin
        busy <= 1'b0;
      end else if (tgt_ready) begin
        if (mode_b) cnt  <= step(cnt, req_q);
        else        pend <= pend & ~pend_oh;
      end
    end
  end
endmodule

// File: rtl/limptr_dir_entry.sv
`timescale 1ns/1ps
module limptr_dir_entry #(
  parameter int NODES = 16,
  parameter int SLOTS = 5,
  localparam int ID_W = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  output logic                    cmd_ready,
  input  logic [2:0]              cmd_op,
  input  logic [ID_W-1:0]         cmd_node,
  output logic                    tgt_valid,
  input  logic                    tgt_ready,
  output logic [ID_W-1:0]         tgt_node,
  output logic                    inval_done,
  output logic [SLOTS-1:0]        sharer_valid,
  output logic [SLOTS*ID_W-1:0]   sharer_ids,
  output logic                    overflow,
  output logic                    owned
);
  import lpdir_pkg::*;

  logic                       acc, busy, done;
  logic                       add_en, rem_en, clr_en, own_en, start;
  logic [ID_W-1:0]            own_node, req_q;
  logic [SLOTS-1:0]           slot_vld, match_vec;
  logic [SLOTS-1:0][ID_W-1:0] slot_id;

  assign cmd_ready = !busy;
  assign acc       = cmd_valid && cmd_ready;
  assign add_en    = acc && (cmd_op == OP_ADD);
  assign rem_en    = acc && (cmd_op == OP_REMOVE);
  assign clr_en    = acc && (cmd_op == OP_CLEAR);
  assign start     = acc && (cmd_op == OP_INVAL);
  assign own_en    = (acc && (cmd_op == OP_OWNER)) || done;
  assign own_node  = done ? req_q : cmd_node;

  lpdir_slot_table #(.NODES(NODES), .SLOTS(SLOTS)) u_tab (
    .clk(clk), .rst_n(rst_n),
    .add_en(add_en), .rem_en(rem_en), .clr_en(clr_en), .own_en(own_en),
    .node(cmd_node), .own_node(own_node),
    .slot_vld(slot_vld), .slot_id(slot_id), .match_vec(match_vec),
    .ovf(overflow), .owned_q(owned)
  );

  lpdir_inval_walker #(.NODES(NODES), .SLOTS(SLOTS)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .start(start), .bcast(overflow), .req_node(cmd_node),
    .pend_init(slot_vld & ~match_vec), .slot_id(slot_id),
    .tgt_ready(tgt_ready), .busy(busy), .tgt_valid(tgt_valid),
    .tgt_node(tgt_node), .done(done), .req_q(req_q)
  );

  assign inval_done   = done;
  assign sharer_valid = slot_vld;

  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : g_pack
      assign sharer_ids[g*ID_W +: ID_W] = slot_id[g];
    end
  endgenerate
endmodule

// File: rtl/lpdir_entry_checks.sv
`timescale 1ns/1ps
module lpdir_entry_checks #(
  parameter int NODES = 16,
  parameter int SLOTS = 5,
  localparam int ID_W = (NODES > 1) ? $clog2(NODES) : 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cmd_valid,
  input logic                  cmd_ready,
  input logic [2:0]            cmd_op,
  input logic [ID_W-1:0]       cmd_node,
  input logic                  tgt_valid,
  input logic                  tgt_ready,
  input logic [ID_W-1:0]       tgt_node,
  input logic                  inval_done,
  input logic [SLOTS-1:0]      sharer_valid,
  input logic [SLOTS*ID_W-1:0] sharer_ids,
  input logic                  overflow,
  input logic                  owned
);
  logic [ID_W-1:0] req_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) req_seen <= '0;
    else if (cmd_valid && cmd_ready && cmd_op == 3'd4) req_seen <= cmd_node;
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid && !tgt_ready |=> tgt_valid && $stable(tgt_node));

  assert_busy_blocks_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid |-> !cmd_ready);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    inval_done |=> !inval_done && owned && !overflow);

  assert_no_list_in_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> sharer_valid == '0);

  assert_owned_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    owned |-> $countones(sharer_valid) == 1);

  assert_skip_requester_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid |-> tgt_node != req_seen);

  always @(posedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < SLOTS; i++)
        for (int j = i + 1; j < SLOTS; j++)
          if (sharer_valid[i] && sharer_valid[j])
            assert_unique_ids_R3: assert (sharer_ids[i*ID_W +: ID_W] != sharer_ids[j*ID_W +: ID_W]);
    end
  end
endmodule

bind limptr_dir_entry lpdir_entry_checks #(.NODES(NODES), .SLOTS(SLOTS)) u_chk (.*);

// File: tb/limptr_dir_entry_test.sv
`timescale 1ns/1ps
module limptr_dir_entry_test;
  localparam int NODES = 16;
  localparam int SLOTS = 5;
  localparam int ID_W  = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, tgt_ready = 1'b1;
  logic [2:0] cmd_op = '0;
  logic [ID_W-1:0] cmd_node = '0;
  logic cmd_ready, tgt_valid, inval_done, overflow, owned;
  logic [ID_W-1:0] tgt_node;
  logic [SLOTS-1:0] sharer_valid;
  logic [SLOTS*ID_W-1:0] sharer_ids;

  int n_chk = 0, n_bad = 0;
  int got[64];
  int n_got;

  always #2.5 clk = ~clk;

  limptr_dir_entry #(.NODES(NODES), .SLOTS(SLOTS)) uut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // op(3) node(4) exp_overflow(1) exp_count(3) exp_owned(1)
  localparam logic [11:0] VEC [16] = '{
    {3'd2, 4'd0,  1'b0, 3'd0, 1'b0},  // R6 clear
    {3'd0, 4'd3,  1'b0, 3'd1, 1'b0},  // R3 add
    {3'd0, 4'd3,  1'b0, 3'd1, 1'b0},  // R3 duplicate
    {3'd0, 4'd7,  1'b0, 3'd2, 1'b0},
    {3'd1, 4'd9,  1'b0, 3'd2, 1'b0},  // R4 absent
    {3'd1, 4'd3,  1'b0, 3'd1, 1'b0},  // R4 remove
    {3'd0, 4'd1,  1'b0, 3'd2, 1'b0},
    {3'd0, 4'd2,  1'b0, 3'd3, 1'b0},
    {3'd0, 4'd4,  1'b0, 3'd4, 1'b0},
    {3'd0, 4'd5,  1'b0, 3'd5, 1'b0},
    {3'd0, 4'd6,  1'b1, 3'd0, 1'b0},  // R5 overflow
    {3'd1, 4'd7,  1'b1, 3'd0, 1'b0},  // R5 remove ignored
    {3'd0, 4'd9,  1'b1, 3'd0, 1'b0},  // R5 add ignored
    {3'd2, 4'd0,  1'b0, 3'd0, 1'b0},  // R6
    {3'd3, 4'd12, 1'b0, 3'd1, 1'b1},  // R7 owner
    {3'd0, 4'd8,  1'b0, 3'd2, 1'b0}   // R7 add clears owned
  };

  task automatic send(input logic [2:0] op, input logic [ID_W-1:0] nd);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_node = nd;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  function automatic int slot_of(input int k);
    return int'(sharer_ids[k*ID_W +: ID_W]);
  endfunction

  // Starts a sweep and collects targets; stall=1 alternates tgt_ready.
  task automatic sweep(input int req, input bit stall);
    int hold;
    bit holding;
    holding = 0; hold = 0; n_got = 0;
    send(3'd4, ID_W'(req));
    chk("R10 cmd_ready low in sweep", int'(cmd_ready), 0);
    for (int it = 0; it < 200; it++) begin
      tgt_ready = stall ? it[0] : 1'b1;
      #0.5;
      if (holding) begin
        chk("R10 target held", int'(tgt_valid && int'(tgt_node) == hold), 1);
        holding = 0;
      end
      if (inval_done) break;
      if (tgt_valid && tgt_ready) begin
        got[n_got] = int'(tgt_node); n_got++;
      end else if (tgt_valid) begin
        holding = 1; hold = int'(tgt_node);
      end
      @(negedge clk);
    end
    tgt_ready = 1'b1;
    @(negedge clk);
    chk("R11 done one cycle", int'(inval_done), 0);
    chk("R11 owned after", int'(owned), 1);
    chk("R11 single slot", $countones(sharer_valid), 1);
    chk("R11 slot0 is requester", slot_of(0), req);
    chk("R11 overflow cleared", int'(overflow), 0);
    chk("R10 cmd_ready back", int'(cmd_ready), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    chk("R1 valid", int'(sharer_valid), 0);
    chk("R1 overflow", int'(overflow), 0);
    chk("R1 owned", int'(owned), 0);
    chk("R1 cmd_ready", int'(cmd_ready), 1);
    chk("R1 tgt_valid", int'(tgt_valid), 0);

    for (int i = 0; i < 16; i++) begin
      send(VEC[i][11:9], VEC[i][8:5]);
      chk($sformatf("R2 vec%0d overflow", i), int'(overflow), int'(VEC[i][4]));
      chk($sformatf("R2 vec%0d count", i), $countones(sharer_valid), int'(VEC[i][3:1]));
      chk($sformatf("R2 vec%0d owned", i), int'(owned), int'(VEC[i][0]));
    end
    // after table: slot0=12, slot1=8
    chk("R3 lowest free slot", slot_of(1), 8);

    // R2 unused codes do nothing
    send(3'd5, 4'd2); send(3'd7, 4'd3);
    chk("R2 unused op count", $countones(sharer_valid), 2);
    chk("R2 unused op slot0", slot_of(0), 12);

    // R4 freed slot reused lowest-first
    send(3'd1, 4'd12);
    send(3'd0, 4'd10);
    chk("R4 reuse slot0", slot_of(0), 10);

    // R8 pointer sweep with back-pressure
    send(3'd2, 4'd0);
    send(3'd0, 4'd3); send(3'd0, 4'd7); send(3'd0, 4'd1);
    sweep(7, 1'b1);
    chk("R8 target count", n_got, 2);
    chk("R8 first target", got[0], 3);
    chk("R8 second target", got[1], 1);

    // R11 empty sweep
    send(3'd2, 4'd0);
    sweep(4, 1'b0);
    chk("R11 no targets", n_got, 0);

    // R9 overflow sweep, requester 0
    send(3'd2, 4'd0);
    for (int k = 0; k < 6; k++) send(3'd0, ID_W'(k + 2));
    chk("R5 overflow set", int'(overflow), 1);
    sweep(0, 1'b0);
    chk("R9 count req0", n_got, 15);
    for (int k = 0; k < 15; k++) chk("R9 order req0", got[k], k + 1);

    // R9 overflow sweep, requester last, stalled
    send(3'd2, 4'd0);
    for (int k = 0; k < 6; k++) send(3'd0, ID_W'(k));
    sweep(15, 1'b1);
    chk("R9 count req15", n_got, 15);
    for (int k = 0; k < 15; k++) chk("R9 order req15", got[k], k);

    // R6 clear after owner
    send(3'd2, 4'd0);
    chk("R6 owned cleared", int'(owned), 0);
    chk("R6 empty", int'(sharer_valid), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule